// File: doc/BRIEF.md
# Cascadable Serial-In Latched Channel Driver

This block takes a bit stream on one serial data pin and moves it into a shift chain on each rising edge of a slow shift clock. A separate storage clock copies the whole chain into a holding register, and that register drives one active-high "sink on" output per channel. An active-low enable can blank every channel without disturbing the held pattern. An active-low clear wipes all state at once.

All slow control pins (shift clock, storage clock, enable, serial data) are brought into one fast system clock domain through two-flop synchronisers, and their edges are found by comparing against a registered copy. The last chain stage is presented on a serial output that moves only on the falling edge of the shift clock. Devices can therefore be chained by wiring one serial output to the next serial input, with the shift and storage clocks shared. The next device then always samples stable data on its own rising edge.

The pins are plain level controls, and there is no valid/ready stream here: the shift clock is the only flow control, and there is no back-pressure. The sender owns the pace, and every shift clock rise is consumed.

Top module: `serial_latch_driver`

## Requirements
- R1: Each detected rising edge of the shift clock moves every chain stage up by one position and loads the synchronised serial data bit into stage 0.
- R2: A detected rising edge of the storage clock copies all WIDTH chain stages in parallel into the storage register. Otherwise the storage register holds its value.
- R3: While the output enable is low, chan_on[i] equals storage bit i, and 1 means the sink is on.
- R4: While the output enable is high, every chan_on bit is 0, and the stored pattern is kept for when the enable returns low.
- R5: Driving the clear low resets the chain, the storage register and the serial output to 0 at once. The release is synchronised to the system clock.
- R6: sdata_out carries the last chain stage (bit WIDTH-1) and changes only on a detected falling edge of the shift clock.
- R7: When rising edges of the shift clock and the storage clock are detected in the same system cycle, the storage register receives the chain contents from before that shift.
- R8: A storage clock pulse given while the clear is low has no effect.
- R9: With two devices chained and 24 bits sent most-significant first, the downstream device latches bits 23..12 and the upstream device latches bits 11..0, with bit 0 of each slice on chan_on[0].
- R10: After the system reset, every channel output and the serial output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| sclk_in | input | 1 | Shift clock, sampled by the system clock |
| lclk_in | input | 1 | Storage clock, sampled by the system clock |
| clr_n_in | input | 1 | Active-low clear of all state |
| oe_n_in | input | 1 | Active-low channel output enable |
| sdata_in | input | 1 | Serial data input |
| sdata_out | output | 1 | Serial cascade output, last chain stage |
| chan_on | output | WIDTH | Channel sink enables, active high |

## Verification
A corrupted chain stage stays hidden until the next storage clock pulse. It then shows as a wrong bit on the matching channel output. The stage at the top of the chain also shows on sdata_out after the next falling shift edge, and through the cascade on the downstream device's slice. Walking a single one through all 24 chained positions ties each chain position to exactly one channel pin of one device. A serial output that moves on the wrong edge shows up as a one-position slip in the downstream slice. Clear and gating faults show up within a few system cycles as channels that stay lit.

// File: rtl/sld_pkg.sv
package sld_pkg;
  // bit positions of the slow control pins inside the synchroniser bus
  localparam int SIG_SCLK  = 0;
  localparam int SIG_LCLK  = 1;
  localparam int SIG_SDATA = 2;
  localparam int SIG_OEN   = 3;
  localparam int NUM_SIG   = 4;

  // reset pattern: enable (active low) starts inactive, all others low
  localparam logic [NUM_SIG-1:0] SIG_RESET = NUM_SIG'(1) << SIG_OEN;
endpackage

// File: rtl/sld_sync_bus.sv
module sld_sync_bus #(
  parameter int                 W       = 4,
  parameter int                 STAGES  = 2,
  parameter logic [W-1:0]       RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sld_clear_sync.sv
module sld_clear_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic core_rst_n
);
  logic [STAGES-1:0] chain;

  // assert at once, release after STAGES system edges
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign core_rst_n = chain[STAGES-1];
endmodule

// File: rtl/sld_shift_chain.sv
module sld_shift_chain #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             sdata,
  output logic [WIDTH-1:0] shreg,
  output logic             sout
);
  localparam int TOP = WIDTH - 1;

  logic sclk_q;
  logic rise, fall;

  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      shreg  <= '0;
      sout   <= 1'b0;
    end else begin
      sclk_q <= sclk;
      if (rise) shreg <= {shreg[TOP-1:0], sdata};
      if (fall) sout  <= shreg[TOP];
    end
  end

  a_r1_stage0: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> shreg[0] == $past(sdata));
  a_r1_move_up: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> shreg[TOP:1] == $past(shreg[TOP-1:0]));
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(shreg));
  a_r6_sout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sout));
  a_r6_sout_take: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> sout == $past(shreg[TOP]));
endmodule

// File: rtl/sld_store_gate.sv
module sld_store_gate #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lclk,
  input  logic             oe_n,
  input  logic [WIDTH-1:0] shreg,
  output logic [WIDTH-1:0] chan_on
);
  logic             lclk_q;
  logic             rise;
  logic [WIDTH-1:0] store;

  assign rise = lclk & ~lclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lclk_q <= 1'b0;
      store  <= '0;
    end else begin
      lclk_q <= lclk;
      if (rise) store <= shreg;
    end
  end

  // one gate per channel
  for (genvar g = 0; g < WIDTH; g++) begin : g_chan
    assign chan_on[g] = store[g] & ~oe_n;
  end

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> store == $past(shreg));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(store));
  a_r4_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n && $past(oe_n)) |-> chan_on == '0);
endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver #(
  parameter int WIDTH       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_in,
  input  logic             lclk_in,
  input  logic             clr_n_in,
  input  logic             oe_n_in,
  input  logic             sdata_in,
  output logic             sdata_out,
  output logic [WIDTH-1:0] chan_on
);
  import sld_pkg::*;

  logic [NUM_SIG-1:0] raw, synced;
  logic               arst_n, core_rst_n;
  logic [WIDTH-1:0]   shreg;

  assign raw[SIG_SCLK]  = sclk_in;
  assign raw[SIG_LCLK]  = lclk_in;
  assign raw[SIG_SDATA] = sdata_in;
  assign raw[SIG_OEN]   = oe_n_in;

  sld_sync_bus #(.W(NUM_SIG), .STAGES(SYNC_STAGES), .RST_VAL(SIG_RESET)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (synced)
  );

  assign arst_n = rst_n & clr_n_in;

  sld_clear_sync #(.STAGES(SYNC_STAGES)) u_clr (
    .clk        (clk),
    .arst_n     (arst_n),
    .core_rst_n (core_rst_n)
  );

  sld_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk   (clk),
    .rst_n (core_rst_n),
    .sclk  (synced[SIG_SCLK]),
    .sdata (synced[SIG_SDATA]),
    .shreg (shreg),
    .sout  (sdata_out)
  );

  sld_store_gate #(.WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .lclk    (synced[SIG_LCLK]),
    .oe_n    (synced[SIG_OEN]),
    .shreg   (shreg),
    .chan_on (chan_on)
  );

  // R5: a low clear empties the outputs in the same cycle
  a_r5_clear_now: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n_in |-> (chan_on == '0 && !sdata_out));
  // R8: storage stays empty right after a clear, whatever the storage clock did
  a_r8_clear_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst_n) |-> chan_on == '0);
endmodule

// File: tb/test_serial_latch_driver.sv
module test_serial_latch_driver;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 12;
  localparam int HALF = 6;

  logic clk = 0, rst_n = 0;
  logic sclk = 0, lclk = 0, clr_n = 1, oe_n = 0, sdata = 0;
  logic link, sout1;
  logic [W-1:0] ch0, ch1;
  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_latch_driver #(.WIDTH(W)) i_serial_latch_driver (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .lclk_in(lclk), .clr_n_in(clr_n),
    .oe_n_in(oe_n), .sdata_in(sdata), .sdata_out(link), .chan_on(ch0));

  serial_latch_driver #(.WIDTH(W)) i_serial_latch_driver_nxt (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .lclk_in(lclk), .clr_n_in(clr_n),
    .oe_n_in(oe_n), .sdata_in(link), .sdata_out(sout1), .chan_on(ch1));

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic shift_word(input logic [23:0] w);
    for (int k = 23; k >= 0; k--) begin
      sdata = w[k];
      wait_cyc(HALF);
      sclk = 1;
      wait_cyc(HALF);
      sclk = 0;
    end
    wait_cyc(HALF);
  endtask

  task automatic pulse_latch();
    lclk = 1;
    wait_cyc(HALF);
    lclk = 0;
    wait_cyc(HALF);
  endtask

  task automatic load_check(input logic [23:0] w);
    shift_word(w);
    pulse_latch();
    check("R9 upstream slice", {20'b0, ch0}, {20'b0, w[11:0]});
    check("R9 downstream slice", {20'b0, ch1}, {20'b0, w[23:12]});
    check("R6 cascade out", {31'b0, sout1}, {31'b0, w[23]});
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [23:0] w;
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(HALF);
    // R10 reset state
    check("R10 ch0", {20'b0, ch0}, 0);
    check("R10 ch1", {20'b0, ch1}, 0);
    check("R10 sout", {30'b0, link, sout1}, 0);

    // R1 R2 R3 R9 walking one over all chained positions
    for (int b = 0; b < 24; b++) load_check(24'd1 << b);
    load_check(24'hFFFFFF);
    load_check(24'h000000);
    load_check(24'hA5C396);
    load_check(24'h3C5AE1);

    // R7 simultaneous edges capture the pre-shift chain; R6 falling-edge update
    w = 24'h5A3C96;
    shift_word(w);            // storage still holds 3C5AE1
    sdata = 1;
    wait_cyc(HALF);
    sclk = 1;
    lclk = 1;
    wait_cyc(HALF);
    check("R7 upstream pre-shift", {20'b0, ch0}, {20'b0, w[11:0]});
    check("R7 downstream pre-shift", {20'b0, ch1}, {20'b0, w[23:12]});
    check("R6 no change on rise", {31'b0, link}, {31'b0, w[11]});
    sclk = 0;
    lclk = 0;
    wait_cyc(HALF);
    check("R6 change on fall", {31'b0, link}, {31'b0, w[10]});
    pulse_latch();
    check("R1 upstream after one shift", {20'b0, ch0}, {20'b0, w[10:0], 1'b1});
    check("R1 downstream after one shift", {20'b0, ch1}, {20'b0, w[22:12], w[11]});

    // R4 gating, R3 restore
    oe_n = 1;
    wait_cyc(HALF);
    check("R4 ch0 blank", {20'b0, ch0}, 0);
    check("R4 ch1 blank", {20'b0, ch1}, 0);
    oe_n = 0;
    wait_cyc(HALF);
    check("R3 ch0 restored", {20'b0, ch0}, {20'b0, w[10:0], 1'b1});
    check("R3 ch1 restored", {20'b0, ch1}, {20'b0, w[22:12], w[11]});

    // R5 clear and R8 storage clock ignored during clear
    load_check(24'hFFFFFF);
    clr_n = 0;
    #1;
    check("R5 ch0 cleared", {20'b0, ch0}, 0);
    check("R5 ch1 cleared", {20'b0, ch1}, 0);
    check("R5 sout cleared", {30'b0, link, sout1}, 0);
    pulse_latch();
    clr_n = 1;
    wait_cyc(HALF);
    check("R8 ch0 after latch in clear", {20'b0, ch0}, 0);
    check("R8 ch1 after latch in clear", {20'b0, ch1}, 0);
    pulse_latch();
    check("R5 chain emptied ch0", {20'b0, ch0}, 0);
    check("R5 chain emptied ch1", {20'b0, ch1}, 0);
    load_check(24'h81F00F);

    done = 1;
    finish_run();
  end
endmodule